// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

A 32-pin general-purpose I/O port controlled through a small memory-mapped register bank. For each pin, software picks one of four uses. The pin can be a software-driven output or a sampled input. It can hand the pad to one of three alternate peripheral functions. Or it can act as an interrupt source. The choice is encoded jointly across three configuration bits per pin. Most configuration registers also answer at two alias addresses, one that sets and one that clears bits. Software can therefore change a single pin without a read-modify-write.

Pad inputs are brought into the clock domain by a two-stage synchronizer. The synchronized levels are readable at offset 0x00 and feed the detection logic. An interrupt pin detects either a level or an edge, and software chooses the polarity. A pin that qualifies latches its own pending flag. The pending flags are gated by a per-pin mask and combined into a single summary interrupt line. The pad electrical circuits and the alternate-function peripherals sit outside this block. The block only drives the per-pin output value, output enable, pull-up enable and alternate-function code.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every configuration register and the pending-flag register read 0, except the pull register (0x30), which reads all ones. `pad_oe`, `pad_pull_en`, `alt_fn_sel` and `irq_out` are all 0.
- R2: Data (0x10), mask (0x20), pull (0x30), function (0x40), select (0x50), direction (0x60) and trigger (0x70) can each be changed in three ways:
  - a write to the base offset replaces the register;
  - a write to base+4 sets every bit written as 1;
  - a write to base+8 clears every bit written as 1.
  For the two alias writes, bits written as 0 keep their value. The new value is readable at the base offset one clock after the write.
- R3: A read of offset 0x00 returns the pad input levels after two clock stages. A pad change driven between edges is not visible after the first rising edge and is visible after the second.
- R4: A pin with function and select bits both 0 is plain GPIO. Its `pad_oe` bit equals its direction bit, and its `pad_out` bit equals its data bit while the direction bit is 1. In every other mode both of these bits are 0.
- R5: With the function bit at 1, `alt_fn_sel[2i+1:2i]` of pin i gives the alternate function:
  - 2'b01 when select is 0;
  - 2'b10 when select is 1 and trigger is 0;
  - 2'b11 when select and trigger are both 1.
  With the function bit at 0 the code is 2'b00.
- R6: `pad_pull_en` is the bitwise inverse of the pull register. A pull bit of 1 turns the pull-up off.
- R7: A pin with function 0 and select 1 is an interrupt source. With trigger 1 it is edge-sensitive. Direction 1 latches its flag on a synchronized rising edge, and direction 0 on a falling edge. The opposite edge does not set the flag.
- R8: An interrupt pin with trigger 0 is level-sensitive. Its flag is set in every cycle in which the synchronized level equals its direction bit: 1 for high, 0 for low.
- R9: Pending flags read at 0x80 stay set until a write to 0x84 with a 1 in that bit position. A write to 0x80 does not change them.
- R10: If a flag-clear write hits a bit in the same cycle that the bit qualifies again, that flag stays set.
- R11: `irq_out` is 1 when at least one pending flag has a mask bit of 0. A mask bit of 1 keeps that pin off `irq_out`, but its flag is still latched.
- R12: A pin that is not in interrupt mode never sets its flag, whatever its pad does. This covers plain GPIO and the alternate functions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; 0 for aliases and unused offsets |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_en | output | 32 | Pull-up enables, active high |
| alt_fn_sel | output | 64 | Two-bit alternate-function code per pin |
| irq_out | output | 1 | Summary interrupt |

## Verification
The detector is driven in four ways:
- rising and falling edges on pins set for the matching polarity and for the opposite one, which tells edge polarity apart;
- a pad level held through a flag clear, which tells a level detector from an edge detector because only the level one sets the flag again;
- a new edge timed to arrive in the same cycle as the clear write, which exposes a wrong priority between set and clear;
- the same pad toggles on pins in plain GPIO and alternate-function modes, where the flags must stay quiet.

The alias addresses get overlapping set and clear patterns over a non-trivial value, so a plain write or a missing mask shows up in the readback.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants, register indices and offset helpers for the
// interrupt-capable GPIO port. Assumes an 8-bit byte-offset register space.
package gpio_port_pkg;

    localparam int REG_AW  = 8;
    localparam int NUM_CFG = 7;

    // Index of each configuration register; offset = 0x10 * (index + 1).
    typedef enum logic [2:0] {
        CFG_DATA = 3'd0,
        CFG_MASK = 3'd1,
        CFG_PULL = 3'd2,
        CFG_FUNC = 3'd3,
        CFG_SEL  = 3'd4,
        CFG_DIR  = 3'd5,
        CFG_TRIG = 3'd6
    } cfg_idx_e;

    localparam logic [REG_AW-1:0] OFS_PIN      = 8'h00;
    localparam logic [REG_AW-1:0] OFS_FLAG     = 8'h80;
    localparam logic [REG_AW-1:0] OFS_FLAG_CLR = 8'h84;

    // Low nibble of an offset inside one register's window.
    localparam logic [3:0] SUB_PLAIN = 4'h0;
    localparam logic [3:0] SUB_SET   = 4'h4;
    localparam logic [3:0] SUB_CLR   = 4'h8;

    // Two-bit alternate-function codes driven per pin.
    localparam logic [1:0] ALT_NONE = 2'b00;
    localparam logic [1:0] ALT_ONE  = 2'b01;
    localparam logic [1:0] ALT_TWO  = 2'b10;
    localparam logic [1:0] ALT_THR  = 2'b11;

    // Base offset of configuration register number idx.
    function automatic logic [REG_AW-1:0] cfg_base(input int idx);
        return REG_AW'((idx + 1) * 16);
    endfunction

endpackage

// File: rtl/gpio_cfg_reg.sv
// Module: one configuration register with a plain write address and
// write-one-to-set / write-one-to-clear aliases at +4 and +8.
// Assumes BASE has a zero low nibble.
module gpio_cfg_reg
    import gpio_port_pkg::*;
#(
    parameter int                 WIDTH   = 32,
    parameter logic [REG_AW-1:0]  BASE    = 8'h10,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  q
);

    logic in_window;
    assign in_window = (addr[REG_AW-1:4] == BASE[REG_AW-1:4]);

    // Apply a plain, set or clear write to the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we && in_window) begin
            case (addr[3:0])
                SUB_PLAIN: q <= wdata;
                SUB_SET:   q <= q | wdata;
                SUB_CLR:   q <= q & ~wdata;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes each pad bit is synchronized on its own, so no bus coherency.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= pad_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin edge/level detector and sticky pending flags.
// Assumes lvl is already synchronous. A new hit wins over a clear in the same cycle.
module gpio_irq_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] irq_en,
    input  logic [WIDTH-1:0] edge_sel,
    input  logic [WIDTH-1:0] pol,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] flag
);

    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] clr_vec;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
        // Decide whether this pin qualifies in the current cycle.
        always_comb begin
            if (!irq_en[gi])
                hit[gi] = 1'b0;
            else if (edge_sel[gi])
                hit[gi] = pol[gi] ? (lvl[gi] & ~prev[gi]) : (~lvl[gi] & prev[gi]);
            else
                hit[gi] = (lvl[gi] == pol[gi]);
        end
    end

    assign clr_vec = clr_en ? clr_bits : '0;

    // Latch pending flags; a hit overrides a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~clr_vec) | hit;
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: per-pin mode decode into pad controls and alternate-function codes.
// Assumes the alternate peripherals drive the pad themselves when selected.
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   data,
    input  logic [WIDTH-1:0]   dir,
    input  logic [WIDTH-1:0]   pull,
    input  logic [WIDTH-1:0]   func,
    input  logic [WIDTH-1:0]   sel,
    input  logic [WIDTH-1:0]   trig,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [WIDTH-1:0]   pad_pull_en,
    output logic [2*WIDTH-1:0] alt_fn_sel,
    output logic [WIDTH-1:0]   irq_en
);

    assign pad_pull_en = ~pull;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
        logic plain;
        assign plain      = ~func[gi] & ~sel[gi];
        assign irq_en[gi] = ~func[gi] &  sel[gi];

        // Drive the pad only in plain GPIO output mode.
        always_comb begin
            pad_oe[gi]  = plain & dir[gi];
            pad_out[gi] = plain & dir[gi] & data[gi];
        end

        // Encode the alternate function from select and trigger.
        always_comb begin
            if (!func[gi])      alt_fn_sel[2*gi +: 2] = ALT_NONE;
            else if (!sel[gi])  alt_fn_sel[2*gi +: 2] = ALT_ONE;
            else if (!trig[gi]) alt_fn_sel[2*gi +: 2] = ALT_TWO;
            else                alt_fn_sel[2*gi +: 2] = ALT_THR;
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
// Module: top of the interrupt-capable GPIO port. Register bank, input
// synchronizer, interrupt detector and pad decode. Combinational read data.
// Assumes a single-cycle write strobe and a byte-offset address.
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [7:0]         bus_addr,
    input  logic [WIDTH-1:0]   bus_wdata,
    output logic [WIDTH-1:0]   bus_rdata,
    input  logic [WIDTH-1:0]   pad_in,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [WIDTH-1:0]   pad_pull_en,
    output logic [2*WIDTH-1:0] alt_fn_sel,
    output logic               irq_out
);

    logic [WIDTH-1:0] cfg_q [NUM_CFG];
    logic [WIDTH-1:0] data_q, mask_q, pull_q, func_q, sel_q, dir_q, trig_q;
    logic [WIDTH-1:0] pin_lvl;
    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] irq_en;
    logic             flag_clr_en;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [WIDTH-1:0] RV =
            (g == int'(CFG_PULL)) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
        gpio_cfg_reg #(
            .WIDTH   (WIDTH),
            .BASE    (cfg_base(g)),
            .RST_VAL (RV)
        ) i_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .q     (cfg_q[g])
        );
    end

    assign data_q = cfg_q[CFG_DATA];
    assign mask_q = cfg_q[CFG_MASK];
    assign pull_q = cfg_q[CFG_PULL];
    assign func_q = cfg_q[CFG_FUNC];
    assign sel_q  = cfg_q[CFG_SEL];
    assign dir_q  = cfg_q[CFG_DIR];
    assign trig_q = cfg_q[CFG_TRIG];

    gpio_in_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .sync_out (pin_lvl)
    );

    assign flag_clr_en = bus_we && (bus_addr == OFS_FLAG_CLR);

    gpio_irq_detect #(
        .WIDTH (WIDTH)
    ) i_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pin_lvl),
        .irq_en   (irq_en),
        .edge_sel (trig_q),
        .pol      (dir_q),
        .clr_en   (flag_clr_en),
        .clr_bits (bus_wdata),
        .flag     (flag_q)
    );

    gpio_pad_ctrl #(
        .WIDTH (WIDTH)
    ) i_pad (
        .data        (data_q),
        .dir         (dir_q),
        .pull        (pull_q),
        .func        (func_q),
        .sel         (sel_q),
        .trig        (trig_q),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .alt_fn_sel  (alt_fn_sel),
        .irq_en      (irq_en)
    );

    // Combine unmasked pending flags into the summary line.
    assign irq_out = |(flag_q & ~mask_q);

    // Return the addressed register; aliases and holes read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_PIN)       bus_rdata = pin_lvl;
        else if (bus_addr == OFS_FLAG) bus_rdata = flag_q;
        else begin
            for (int k = 0; k < NUM_CFG; k++)
                if (bus_addr == cfg_base(k)) bus_rdata = cfg_q[k];
        end
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
// Module: assertion checker for gpio_irq_port, attached by bind below.
// Assumes the offsets from gpio_port_pkg.
module gpio_irq_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [7:0]         bus_addr,
    input logic [WIDTH-1:0]   bus_wdata,
    input logic [WIDTH-1:0]   pad_oe,
    input logic [2*WIDTH-1:0] alt_fn_sel,
    input logic [WIDTH-1:0]   data_q,
    input logic [WIDTH-1:0]   func_q,
    input logic [WIDTH-1:0]   sel_q,
    input logic [WIDTH-1:0]   flag_q
);

    localparam logic [7:0] DATA_SET = cfg_base(int'(CFG_DATA)) + 8'h4;
    localparam logic [7:0] DATA_CLR = cfg_base(int'(CFG_DATA)) + 8'h8;

    AST_SET_ALIAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DATA_SET) |=> ((data_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_CLR_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DATA_CLR) |=> ((data_q & $past(bus_wdata)) == '0)); // R2

    AST_NO_OE_OUTSIDE_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & (func_q | sel_q)) == '0)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_FLAG_CLR) |=> (($past(flag_q) & ~flag_q) == '0)); // R9

    AST_FLAG_ONLY_IRQ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag_q & ~$past(flag_q) & ~$past(sel_q & ~func_q)) == '0)); // R12

    for (genvar g = 0; g < WIDTH; g++) begin : g_alt
        AST_ALT_NEEDS_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
            !func_q[g] |-> (alt_fn_sel[2*g +: 2] == ALT_NONE)); // R5
    end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_oe     (pad_oe),
    .alt_fn_sel (alt_fn_sel),
    .data_q     (data_q),
    .func_q     (func_q),
    .sel_q      (sel_q),
    .flag_q     (flag_q)
);

// File: tb/test_gpio_irq_port.sv
// Directed bench for gpio_irq_port: one task per scenario, each self-checking.
module test_gpio_irq_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pull_en;
    logic [63:0] alt_fn_sel;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    gpio_irq_port i_gpio_irq_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .alt_fn_sel  (alt_fn_sel),
        .irq_out     (irq_out)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 1; k <= 7; k++) begin
            rd(8'(k * 16), v);
            chk("R1", $sformatf("cfg reg 0x%0h", k * 16), v, (k == 3) ? 32'hFFFF_FFFF : 32'h0);
        end
        rd(8'h80, v);  chk("R1", "flags", v, 0);
        chk("R1", "pad_oe", pad_oe, 0);
        chk("R1", "pad_pull_en", pad_pull_en, 0);
        chk("R1", "alt_fn_sel", alt_fn_sel, 0);
        chk("R1", "irq_out", irq_out, 0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'h20, 32'hF0F0_0000);
        rd(8'h20, v); chk("R2", "plain write", v, 32'hF0F0_0000);
        wr(8'h24, 32'h0000_000F);
        rd(8'h20, v); chk("R2", "set alias", v, 32'hF0F0_000F);
        wr(8'h28, 32'h00F0_0001);
        rd(8'h20, v); chk("R2", "clear alias", v, 32'hF000_000E);
        wr(8'h20, 32'h0);
    endtask

    task automatic t_pin_sync();
        logic [31:0] v;
        pad_in = 32'h5A00_0000;
        @(posedge clk); @(negedge clk);
        rd(8'h00, v); chk("R3", "pin after one edge", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(8'h00, v); chk("R3", "pin after two edges", v, 32'h5A00_0000);
        pad_in = '0;
        idle(3);
    endtask

    task automatic t_gpio_out();
        wr(8'h60, 32'h0000_00F0);
        wr(8'h10, 32'h0000_0030);
        chk("R4", "pad_oe plain", pad_oe, 32'h0000_00F0);
        chk("R4", "pad_out plain", pad_out, 32'h0000_0030);
        wr(8'h54, 32'h0000_0010);
        chk("R4", "pad_oe irq pin", pad_oe, 32'h0000_00E0);
        chk("R4", "pad_out irq pin", pad_out, 32'h0000_0020);
        wr(8'h50, 0); wr(8'h60, 0); wr(8'h10, 0);
        wr(8'h84, 32'hFFFF_FFFF);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        wr(8'h44, 32'h0070_0000);
        wr(8'h54, 32'h0060_0000);
        wr(8'h74, 32'h0040_0000);
        wr(8'h64, 32'h0070_0000);
        chk("R5", "pin20 code", alt_fn_sel[41:40], 2'b01);
        chk("R5", "pin21 code", alt_fn_sel[43:42], 2'b10);
        chk("R5", "pin22 code", alt_fn_sel[45:44], 2'b11);
        chk("R5", "alt pins not driven", pad_oe, 0);
        pad_in[21] = 1'b1; idle(4); pad_in[21] = 1'b0; idle(4);
        rd(8'h80, v); chk("R12", "no flag in alt mode", v, 0);
        wr(8'h40, 0); wr(8'h50, 0); wr(8'h70, 0); wr(8'h60, 0);
    endtask

    task automatic t_pull();
        wr(8'h38, 32'h0000_00FF);
        chk("R6", "pull enable after clear", pad_pull_en, 32'h0000_00FF);
        wr(8'h34, 32'h0000_000F);
        chk("R6", "pull enable after set", pad_pull_en, 32'h0000_00F0);
    endtask

    task automatic t_non_irq();
        logic [31:0] v;
        pad_in[10] = 1'b1; idle(4); pad_in[10] = 1'b0; idle(4);
        rd(8'h80, v); chk("R12", "no flag in gpio input mode", v, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(8'h64, 32'h0000_0008); wr(8'h74, 32'h0000_0028);
        wr(8'h54, 32'h0000_0028);
        wr(8'h84, 32'hFFFF_FFFF);
        pad_in[3] = 1'b1; idle(4);
        rd(8'h80, v); chk("R7", "rising edge flag", v, 32'h0000_0008);
        chk("R11", "irq_out unmasked", irq_out, 1);
        wr(8'h84, 32'h0000_0008);
        pad_in[3] = 1'b0; idle(4);
        rd(8'h80, v); chk("R7", "falling edge ignored on rising pin", v, 0);
        pad_in[5] = 1'b1; idle(4);
        rd(8'h80, v); chk("R7", "rising ignored on falling pin", v, 0);
        pad_in[5] = 1'b0; idle(4);
        rd(8'h80, v); chk("R7", "falling edge flag", v, 32'h0000_0020);
        wr(8'h84, 32'h0000_0020);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(8'h64, 32'h0000_0080);
        wr(8'h54, 32'h0000_0080);
        idle(2);
        rd(8'h80, v); chk("R8", "high level pin idle low", v[7], 0);
        pad_in[7] = 1'b1; idle(4);
        wr(8'h84, 32'h0000_0080); idle(1);
        rd(8'h80, v); chk("R8", "high level re-flags after clear", v[7], 1);
        pad_in[7] = 1'b0; idle(4);
        wr(8'h84, 32'h0000_0080);
        rd(8'h80, v); chk("R8", "cleared once level gone", v[7], 0);
        wr(8'h54, 32'h0000_0100); idle(2);
        rd(8'h80, v); chk("R8", "low level pin flags", v[8], 1);
        pad_in[8] = 1'b1; idle(4);
        wr(8'h84, 32'h0000_0100);
        rd(8'h80, v); chk("R8", "low level pin cleared when high", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(8'h24, 32'h0000_0008);
        pad_in[3] = 1'b1; idle(4);
        rd(8'h80, v); chk("R11", "flag latched while masked", v, 32'h0000_0008);
        chk("R11", "irq_out masked", irq_out, 0);
        wr(8'h28, 32'h0000_0008);
        chk("R11", "irq_out after unmask", irq_out, 1);
        wr(8'h84, 32'h0000_0008);
        chk("R11", "irq_out after clear", irq_out, 0);
        pad_in[3] = 1'b0; idle(4);
    endtask

    task automatic t_flag_clear();
        logic [31:0] v;
        pad_in[3] = 1'b1; idle(4);
        pad_in[3] = 1'b0; idle(4);
        wr(8'h80, 32'h0);
        rd(8'h80, v); chk("R9", "write to flag offset ignored", v, 32'h0000_0008);
        pad_in[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(8'h84, 32'h0000_0008);
        rd(8'h80, v); chk("R10", "edge beats clear", v, 32'h0000_0008);
        wr(8'h84, 32'h0000_0008);
        rd(8'h80, v); chk("R9", "clear with no new edge", v, 0);
        chk("R9", "irq_out low after clear", irq_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alias();
        t_pin_sync();
        t_gpio_out();
        t_alt();
        t_pull();
        t_non_irq();
        t_edge();
        t_level();
        t_mask();
        t_flag_clear();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule